// File: doc/BRIEF.md
# Beacon Schedule Timer

This block keeps the station's free-running microsecond timestamp and turns it into the periodic events a wireless MAC needs around each beacon. Four compare timers are held. The beacon-time timer and the announcement-window-end timer count in time units of 1024 us. The DMA-alert timer and the software-alert timer count in eighths of a time unit, which is 128 us. A timer fires when the matching slice of the timestamp equals its value. After it fires, it advances itself by one beacon period, scaled to its own resolution. This means the next interval needs no software work.

Software configures the block through a small write port. It writes the timer values first, and then writes the control word, which holds the period, the enable, the timestamp-clear request and a TIM offset. The control write is what arms the timers. A three-state machine tracks arming:

- `ST_IDLE`: nothing armed.
- `ST_STAGED`: a timer was written and waits for the control write.
- `ST_RUN`: compares are live.

The transitions are:

- A timer write moves IDLE or RUN to STAGED.
- A control write with the enable bit set moves IDLE or STAGED to RUN.
- A control write with the enable bit clear moves STAGED or RUN to IDLE.
- Any other cycle holds the state.

Top module: `bcn_timer_unit`

## Requirements
- R1: After reset the timestamp is 0. It increases by exactly one every CLK_PER_US clock cycles and never changes by more than one per cycle.
- R2: A write to address 4 with bit 30 set clears the timestamp and its prescaler at that clock edge, so the next cycle reads 0. The bit is not stored, so later cycles count normally.
- R3: A write to a timer address moves the block to STAGED. While it is not in RUN, no event pulse is produced. The timer addresses are:
  - 0: beacon time.
  - 1: DMA alert.
  - 2: software alert.
  - 3: window end.
- R4: In RUN, the beacon-time event pulses for one cycle, in the cycle after timestamp bits [10 +: TMR_W] equal the beacon timer. The timer then advances by the period, taken from bits [15:0] of the control word.
- R5: The DMA-alert and software-alert timers compare against timestamp bits [7 +: TMR_W]. They advance by eight times the period after firing.
- R6: The window-end timer compares in time units. When a control write sets the enable bit (bit 31) and the window-end value is not greater than the beacon time, the window-end value is replaced by the beacon time plus one.
- R7: A beacon timer value of 0 means no beacons, and it produces no beacon-time event.
- R8: A control write with bit 31 clear returns the block to IDLE, and no event follows.
- R9: `tim_slot` takes the 6-bit offset in control bits [21:16] plus 4 when that offset is nonzero, and 0 when it is zero. It is updated on each control write.
- R10: With a nonzero period, every event output is high for a single cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 3 | Write address: 0 to 3 are the timers, 4 is the control word |
| cfg_wdata | input | 32 | Write data |
| tsf_now | output | TSF_W | Timestamp in microseconds |
| ev_tbtt | output | 1 | Beacon-time event pulse |
| ev_dma_alert | output | 1 | DMA-alert event pulse |
| ev_sw_alert | output | 1 | Software-alert event pulse |
| ev_atim_end | output | 1 | Window-end event pulse |
| tim_slot | output | TIM_W+1 | Derived TIM offset |

## Verification
The hardest case to reach is a single schedule in which all four timers fire and reload several times across a few beacon periods. In the same run, the window-end clamp must have taken effect, which needs a timestamp that advances through thousands of microseconds. The stimulus gets there in three steps:

- It programs small time-unit values and a two-unit period.
- It sets the clear bit on the arming write, so the schedule starts from a known zero.
- It runs the prescaler at two cycles per microsecond, which keeps the run within a few tens of thousands of cycles.

A behavioural model follows the timestamp, the arming state and every timer, so each pulse is checked in the exact cycle it appears.

// File: rtl/bcn_pkg.sv
package bcn_pkg;
    localparam int NUM_TMR  = 4;
    localparam int TMR_TBTT = 0;
    localparam int TMR_DMA  = 1;
    localparam int TMR_SW   = 2;
    localparam int TMR_ATIM = 3;

    localparam logic [2:0] ADDR_CTRL = 3'd4;

    localparam int CTRL_PER_LSB = 0;
    localparam int CTRL_TIM_LSB = 16;
    localparam int CTRL_CLR_BIT = 30;
    localparam int CTRL_EN_BIT  = 31;

    localparam int SH_FINE = 7;
    localparam int SH_TU   = 10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STAGED = 2'd1,
        ST_RUN    = 2'd2
    } bcn_state_e;
endpackage

// File: rtl/bcn_tsf.sv
module bcn_tsf #(
    parameter int TSF_W      = 32,
    parameter int CLK_PER_US = 125
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [TSF_W-1:0] tsf_q
);
    localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

    logic [PRE_W-1:0] pre_q;
    logic             tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            tsf_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
            tsf_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            tsf_q <= tsf_q + TSF_W'(1);
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/bcn_arm_fsm.sv
module bcn_arm_fsm
    import bcn_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PER_W  = 16,
    parameter int TIM_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output bcn_state_e        state_q,
    output logic              arm,
    output logic              tsf_clr,
    output logic [PER_W-1:0]  period_q,
    output logic [TIM_W:0]    tim_slot_q
);
    logic       tmr_wr;
    logic       ctl_wr;
    logic       en_bit;
    bcn_state_e state_d;
    logic [TIM_W-1:0] tim_off;
    logic       unused_ctl;

    assign tmr_wr  = we && (addr < ADDR_CTRL);
    assign ctl_wr  = we && (addr == ADDR_CTRL);
    assign en_bit  = wdata[CTRL_EN_BIT];
    assign arm     = ctl_wr && en_bit;
    assign tsf_clr = ctl_wr && wdata[CTRL_CLR_BIT];
    assign tim_off = wdata[CTRL_TIM_LSB +: TIM_W];
    assign unused_ctl = ^wdata[CTRL_CLR_BIT-1:CTRL_TIM_LSB+TIM_W]
                      ^ ^wdata[CTRL_TIM_LSB-1:CTRL_PER_LSB+PER_W];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tmr_wr)              state_d = ST_STAGED;
                else if (ctl_wr && en_bit) state_d = ST_RUN;
            end
            ST_STAGED: begin
                if (ctl_wr)              state_d = en_bit ? ST_RUN : ST_IDLE;
            end
            ST_RUN: begin
                if (tmr_wr)              state_d = ST_STAGED;
                else if (ctl_wr && !en_bit) state_d = ST_IDLE;
            end
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q   <= '0;
            tim_slot_q <= '0;
        end else if (ctl_wr) begin
            period_q   <= wdata[CTRL_PER_LSB +: PER_W];
            tim_slot_q <= (tim_off != '0) ? ({1'b0, tim_off} + (TIM_W+1)'(4)) : '0;
        end
    end
endmodule

// File: rtl/bcn_cmp_timer.sv
module bcn_cmp_timer #(
    parameter int TMR_W     = 20,
    parameter int PER_W     = 16,
    parameter bit FINE      = 1'b0,
    parameter bit MUTE_ZERO = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] slice,
    input  logic             run,
    input  logic             hold,
    input  logic             load_en,
    input  logic [TMR_W-1:0] load_val,
    input  logic             force_en,
    input  logic [TMR_W-1:0] force_val,
    input  logic [PER_W-1:0] period,
    output logic [TMR_W-1:0] val_q,
    output logic             evt_q
);
    localparam int SCL = FINE ? 3 : 0;

    logic [TMR_W-1:0] inc;
    logic             muted;
    logic             fire;

    assign inc   = {{(TMR_W-PER_W){1'b0}}, period} << SCL;
    assign muted = MUTE_ZERO && (val_q == '0);
    assign fire  = run && !hold && !muted && (slice == val_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= fire;
            if (load_en)       val_q <= load_val;
            else if (force_en) val_q <= force_val;
            else if (fire)     val_q <= val_q + inc;
        end
    end
endmodule

// File: rtl/bcn_timer_unit.sv
module bcn_timer_unit
    import bcn_pkg::*;
#(
    parameter int TSF_W      = 32,
    parameter int TMR_W      = 20,
    parameter int PER_W      = 16,
    parameter int TIM_W      = 6,
    parameter int DATA_W     = 32,
    parameter int CLK_PER_US = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [TSF_W-1:0]  tsf_now,
    output logic              ev_tbtt,
    output logic              ev_dma_alert,
    output logic              ev_sw_alert,
    output logic              ev_atim_end,
    output logic [TIM_W:0]    tim_slot
);
    bcn_state_e       state_q;
    logic             arm;
    logic             tsf_clr;
    logic [PER_W-1:0] period_q;
    logic [TMR_W-1:0] tmr_val [NUM_TMR];
    logic [NUM_TMR-1:0] evt_vec;
    logic [TMR_W-1:0] tbtt_val;
    logic [TMR_W-1:0] tbtt_next;
    logic             atim_fix;
    logic [TMR_W-1:0] fine_slice;
    logic [TMR_W-1:0] tu_slice;

    bcn_tsf #(.TSF_W(TSF_W), .CLK_PER_US(CLK_PER_US)) u_tsf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tsf_clr),
        .tsf_q (tsf_now)
    );

    bcn_arm_fsm #(.DATA_W(DATA_W), .PER_W(PER_W), .TIM_W(TIM_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .state_q    (state_q),
        .arm        (arm),
        .tsf_clr    (tsf_clr),
        .period_q   (period_q),
        .tim_slot_q (tim_slot)
    );

    assign fine_slice = tsf_now[SH_FINE +: TMR_W];
    assign tu_slice   = tsf_now[SH_TU +: TMR_W];
    assign tbtt_val   = tmr_val[TMR_TBTT];
    assign tbtt_next  = tbtt_val + TMR_W'(1);
    assign atim_fix   = arm && (tmr_val[TMR_ATIM] <= tbtt_val);

    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
        localparam bit FINE = (gi == TMR_DMA) || (gi == TMR_SW);
        localparam bit MUTE = (gi == TMR_TBTT);
        bcn_cmp_timer #(
            .TMR_W(TMR_W), .PER_W(PER_W), .FINE(FINE), .MUTE_ZERO(MUTE)
        ) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .slice     (FINE ? fine_slice : tu_slice),
            .run       (state_q == ST_RUN),
            .hold      (cfg_we),
            .load_en   (cfg_we && (cfg_addr == 3'(gi))),
            .load_val  (cfg_wdata[TMR_W-1:0]),
            .force_en  ((gi == TMR_ATIM) ? atim_fix : 1'b0),
            .force_val (tbtt_next),
            .period    (period_q),
            .val_q     (tmr_val[gi]),
            .evt_q     (evt_vec[gi])
        );
    end

    assign ev_tbtt      = evt_vec[TMR_TBTT];
    assign ev_dma_alert = evt_vec[TMR_DMA];
    assign ev_sw_alert  = evt_vec[TMR_SW];
    assign ev_atim_end  = evt_vec[TMR_ATIM];
endmodule

// File: rtl/bcn_timer_unit_chk.sv
module bcn_timer_unit_chk
    import bcn_pkg::*;
#(
    parameter int TSF_W  = 32,
    parameter int TMR_W  = 20,
    parameter int PER_W  = 16,
    parameter int TIM_W  = 6,
    parameter int DATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [2:0]         cfg_addr,
    input logic [DATA_W-1:0]  cfg_wdata,
    input logic [TSF_W-1:0]   tsf_now,
    input logic [3:0]         evt_vec,
    input logic [TIM_W:0]     tim_slot,
    input bcn_state_e         state_q,
    input logic [PER_W-1:0]   period_q,
    input logic [TMR_W-1:0]   tbtt_val
);
    logic ctl_wr;
    logic clr_req;
    logic [TIM_W-1:0] off;

    assign ctl_wr  = cfg_we && (cfg_addr == ADDR_CTRL);
    assign clr_req = ctl_wr && cfg_wdata[CTRL_CLR_BIT];
    assign off     = cfg_wdata[CTRL_TIM_LSB +: TIM_W];

    // R1
    p_tsf_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_req |=> (tsf_now == $past(tsf_now)) || (tsf_now == $past(tsf_now) + TSF_W'(1)));

    // R2
    p_tsf_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (tsf_now == '0));

    // R3
    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |=> (evt_vec == 4'b0));

    // R7
    p_tbtt_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tbtt_val == '0) |=> !evt_vec[0]);

    // R8
    p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !cfg_wdata[CTRL_EN_BIT]) |=> (state_q == ST_IDLE));

    // R9
    p_tim_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (tim_slot == (($past(off) != '0) ? ({1'b0, $past(off)} + (TIM_W+1)'(4)) : '0)));

    // R10
    p_tbtt_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec[0] && (period_q != '0)) |=> !evt_vec[0]);
endmodule

bind bcn_timer_unit bcn_timer_unit_chk #(
    .TSF_W(TSF_W), .TMR_W(TMR_W), .PER_W(PER_W), .TIM_W(TIM_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .tsf_now   (tsf_now),
    .evt_vec   (evt_vec),
    .tim_slot  (tim_slot),
    .state_q   (state_q),
    .period_q  (period_q),
    .tbtt_val  (tbtt_val)
);

// File: tb/sim_bcn_timer_unit.sv
module sim_bcn_timer_unit;
    localparam int CPU   = 2;
    localparam int TMR_W = 20;
    localparam longint MASK = (64'd1 << TMR_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] tsf_now;
    logic        ev_tbtt, ev_dma_alert, ev_sw_alert, ev_atim_end;
    logic [6:0]  tim_slot;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;
    int cnt [4];

    always #4 clk = ~clk;

    bcn_timer_unit #(.TMR_W(TMR_W), .CLK_PER_US(CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tsf_now(tsf_now), .ev_tbtt(ev_tbtt),
        .ev_dma_alert(ev_dma_alert), .ev_sw_alert(ev_sw_alert),
        .ev_atim_end(ev_atim_end), .tim_slot(tim_slot)
    );

    // behavioural reference
    longint m_tsf, m_pre, m_per, m_tim;
    longint m_tmr [4];
    int     m_state;   // 0 idle, 1 staged, 2 run
    logic [3:0] m_evt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tsf = 0; m_pre = 0; m_per = 0; m_tim = 0; m_state = 0; m_evt = '0;
            for (int i = 0; i < 4; i++) m_tmr[i] = 0;
        end else begin
            longint sl;
            logic [3:0] f;
            for (int i = 0; i < 4; i++) begin
                sl = (i == 1 || i == 2) ? ((m_tsf >> 7) & MASK) : ((m_tsf >> 10) & MASK);
                f[i] = (m_state == 2) && !cfg_we && (sl == m_tmr[i]) && !(i == 0 && m_tmr[0] == 0);
            end
            m_evt = f;
            for (int i = 0; i < 4; i++) begin
                if (cfg_we && cfg_addr == 3'(i)) m_tmr[i] = longint'(cfg_wdata) & MASK;
                else if (f[i]) m_tmr[i] = (m_tmr[i] + m_per * ((i == 1 || i == 2) ? 8 : 1)) & MASK;
            end
            if (cfg_we && cfg_addr == 3'd4) begin
                if (cfg_wdata[31] && m_tmr[3] <= m_tmr[0]) m_tmr[3] = (m_tmr[0] + 1) & MASK;
                m_state = cfg_wdata[31] ? 2 : 0;
                m_per = longint'(cfg_wdata[15:0]);
                m_tim = (cfg_wdata[21:16] != 0) ? longint'(cfg_wdata[21:16]) + 4 : 0;
            end else if (cfg_we && cfg_addr < 3'd4) begin
                m_state = 1;
            end
            if (cfg_we && cfg_addr == 3'd4 && cfg_wdata[30]) begin
                m_tsf = 0; m_pre = 0;
            end else if (m_pre == CPU - 1) begin
                m_pre = 0; m_tsf = m_tsf + 1;
            end else begin
                m_pre = m_pre + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R1, R4, R5, R6, R9, R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] dv;
            dv = {ev_atim_end, ev_sw_alert, ev_dma_alert, ev_tbtt};
            chk(longint'(tsf_now) == m_tsf, "R1 tsf track", longint'(tsf_now), m_tsf);
            chk(dv == m_evt, "R4/R5/R6/R10 events", longint'(dv), longint'(m_evt));
            chk(longint'(tim_slot) == m_tim, "R9 tim slot", longint'(tim_slot), m_tim);
            for (int i = 0; i < 4; i++) if (dv[i]) cnt[i]++;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clr_cnt();
        for (int i = 0; i < 4; i++) cnt[i] = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        clr_cnt();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tsf_now == 0, "R1 reset tsf", longint'(tsf_now), 0);
        chk({ev_tbtt, ev_dma_alert, ev_sw_alert, ev_atim_end} == 4'b0, "R1 reset events", 0, 0);
        rst_n = 1'b1;

        // main schedule: beacon 2 TU, DMA 13/8, SW 14/8, window 2 (clamped to 3), period 2
        wr(3'd0, 32'd2);
        wr(3'd1, 32'd13);
        wr(3'd2, 32'd14);
        wr(3'd3, 32'd2);
        clr_cnt();
        idle(500);
        chk(cnt[0] + cnt[1] + cnt[2] + cnt[3] == 0, "R3 staged quiet", cnt[0], 0);
        wr(3'd4, (32'd1 << 31) | (32'd1 << 30) | (32'd5 << 16) | 32'd2);
        clr_cnt();
        idle(13400);
        chk(cnt[0] == 3, "R4 beacon count", cnt[0], 3);
        chk(cnt[1] == 3, "R5 dma count", cnt[1], 3);
        chk(cnt[2] == 3, "R5 sw count", cnt[2], 3);
        chk(cnt[3] == 2, "R6 window clamp count", cnt[3], 2);
        chk(tim_slot == 7'd9, "R9 offset plus four", longint'(tim_slot), 9);

        // R3: a timer write stops events until re-armed
        wr(3'd1, 32'd0);
        clr_cnt();
        idle(6000);
        chk(cnt[0] + cnt[1] + cnt[2] + cnt[3] == 0, "R3 disarmed by timer write", cnt[0] + cnt[3], 0);

        // R8: disable write
        wr(3'd4, 32'd2);
        clr_cnt();
        idle(5000);
        chk(cnt[0] + cnt[1] + cnt[2] + cnt[3] == 0, "R8 disabled quiet", cnt[0] + cnt[3], 0);
        chk(tim_slot == 7'd0, "R9 zero offset", longint'(tim_slot), 0);

        // R7: beacon 0, alerts parked, window 1, period 3
        wr(3'd0, 32'd0);
        wr(3'd1, 32'h0FFFF);
        wr(3'd2, 32'h7FFFF);
        wr(3'd3, 32'd1);
        wr(3'd4, (32'd1 << 31) | (32'd1 << 30) | (32'd2 << 16) | 32'd3);
        clr_cnt();
        idle(10400);
        chk(cnt[0] == 0, "R7 no beacon event", cnt[0], 0);
        chk(cnt[3] == 2, "R6 window unclamped count", cnt[3], 2);
        chk(cnt[1] + cnt[2] == 0, "R5 parked alerts", cnt[1] + cnt[2], 0);
        chk(tim_slot == 7'd6, "R9 offset two", longint'(tim_slot), 6);

        // R2: clear mid-run
        wr(3'd4, (32'd1 << 31) | (32'd1 << 30) | 32'd3);
        chk(tsf_now == 0, "R2 cleared", longint'(tsf_now), 0);
        idle(20);
        chk(tsf_now == 10, "R2 counts after clear", longint'(tsf_now), 10);

        finish_run();
    end
endmodule